// File: doc/BRIEF.md
# Polling Receiver Duty-Cycle Sequencer

This block sets how often a low-power radio receiver is awake. While polling is enabled, it runs a loop. First the front end sleeps for a programmable time. Then the front end is powered for a fixed start-up interval. Last, a separate edge-timing checker is told to start a bit check. If the checker reports a failure, the loop goes back to sleep. If it reports a pass, the sequencer holds the receiver in receiving mode until an off command arrives.

The sleep time is a 5-bit code times a unit of `UNIT_CYC` base clocks (1024 by default). An optional extension multiplies it by 1, 2, 4 or 8. The all-ones code parks the receiver in a sleep it never leaves by itself. All timers run on the single base clock. Every pin is a plain level or pulse control signal with no handshake. Configuration inputs are sampled at the edge where a sleep period begins.

Top module: `rx_poll_seq`

## Requirements
- R1: During reset and after it, with `poll_en_i` low, `fe_pwr_o`, `chk_start_o` and `rx_mode_o` are all 0.
- R2: While `poll_en_i` is low, the sequencer is idle and all outputs are 0 from the cycle after the low is sampled, whatever state it was in. A high `poll_en_i` sampled while idle starts a sleep period at the next edge.
- R3: With the extension not applied, a sleep period lasts `sleep_code_i` × `UNIT_CYC` cycles, with `fe_pwr_o` low. Code 0 gives a one-cycle sleep.
- R4: If `ext_active_i` is high at the edge where a sleep period begins, that period is multiplied by 2^`ext_sel_i` (selector values 0,1,2,3 give factors 1,2,4,8). Later changes to the inputs do not affect a period already running.
- R5: A sleep begun with code 31 (all ones) never ends by itself, even if the code is changed during it. Only taking `poll_en_i` low and then high again restarts polling.
- R6: `fe_pwr_o` rises in the first start-up cycle and stays high through start-up, check and receiving. Start-up lasts `STARTUP_CYC` cycles. `chk_start_o` is then a single-cycle pulse in the first check cycle.
- R7: `chk_done_i` and `chk_pass_i` have no effect outside the check phase. In particular, a pass reported during start-up neither shortens start-up nor enters receiving mode.
- R8: In the check phase, `chk_done_i` with `chk_pass_i` high sets `rx_mode_o` at the next edge. With `chk_pass_i` low, the sequencer returns to sleep at the next edge and `fe_pwr_o` falls.
- R9: `off_cmd_i` sampled in receiving mode clears `rx_mode_o` and `fe_pwr_o` at the next edge and begins a new sleep period of the configured length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock driving all timers |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_en_i | input | 1 | High turns polling on, low forces idle |
| sleep_code_i | input | 5 | Sleep length in units of `UNIT_CYC` clocks; 31 = permanent sleep |
| ext_sel_i | input | 2 | Extension factor select: 2^value |
| ext_active_i | input | 1 | Apply the extension factor to the next sleep period |
| chk_done_i | input | 1 | Bit-check result valid (used only in check phase) |
| chk_pass_i | input | 1 | Bit-check verdict: 1 pass, 0 fail |
| off_cmd_i | input | 1 | Leave receiving mode and resume polling |
| fe_pwr_o | output | 1 | Front-end power enable |
| chk_start_o | output | 1 | One-cycle strobe that starts the bit check |
| rx_mode_o | output | 1 | Receiver is in receiving mode |

## Verification
The case hardest to reach from the ports is a permanent sleep that was entered through the normal loop, and then showing that nothing but the enable can end it. The stimulus first runs a full wake and check with a finite code. It switches to code 31 just before reporting a failed check, so that the all-ones value is captured at the start of a sleep. It then changes the code back to a small value while the receiver stays dark for tens of thousands of cycles. Only after that does it toggle the enable and measure the new, finite sleep.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_SLEEP = 3'd1,
    PS_WAKE  = 3'd2,
    PS_CHECK = 3'd3,
    PS_RECV  = 3'd4
  } poll_state_e;

endpackage

// File: rtl/rx_poll_sleep_tmr.sv
module rx_poll_sleep_tmr #(
  parameter int SLEEP_W  = 5,
  parameter int EXT_W    = 2,
  parameter int UNIT_CYC = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               run_i,
  input  logic [SLEEP_W-1:0] code_i,
  input  logic [EXT_W-1:0]   sel_i,
  input  logic               ext_i,
  output logic               done_o
);
  localparam int MAX_SH  = (1 << EXT_W) - 1;
  localparam int UNITS_W = SLEEP_W + MAX_SH;
  localparam int PRE_W   = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYC - 1);

  logic [UNITS_W-1:0] units_ld;
  logic [UNITS_W-1:0] rem_q;
  logic [PRE_W-1:0]   pre_q;
  logic               perm_q;

  // units to sleep: code, optionally shifted by the extension selector
  always_comb begin
    units_ld = UNITS_W'(code_i);
    if (ext_i) units_ld = units_ld << sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      pre_q  <= '0;
      perm_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= units_ld;
      pre_q  <= '0;
      perm_q <= &code_i;
    end else if (run_i) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (rem_q != '0) rem_q <= rem_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // done in the last cycle of the period (or at once for zero units)
  assign done_o = !perm_q &&
                  ((rem_q == '0) || ((rem_q == UNITS_W'(1)) && (pre_q == PRE_LAST)));

endmodule

// File: rtl/rx_poll_wake_tmr.sv
module rx_poll_wake_tmr #(
  parameter int STARTUP_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load_i)                     cnt_q <= '0;
    else if (run_i && cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
  import rx_poll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sleep_done_i,
  input  logic wake_done_i,
  input  logic chk_done_i,
  input  logic chk_pass_i,
  input  logic off_i,
  output logic sleep_load_o,
  output logic sleep_run_o,
  output logic wake_load_o,
  output logic wake_run_o,
  output logic fe_pwr_o,
  output logic chk_start_o,
  output logic rx_mode_o
);
  poll_state_e st_q, st_d;
  logic        in_check_q;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = PS_IDLE;
    end else begin
      unique case (st_q)
        PS_IDLE:  st_d = PS_SLEEP;
        PS_SLEEP: if (sleep_done_i) st_d = PS_WAKE;
        PS_WAKE:  if (wake_done_i) st_d = PS_CHECK;
        PS_CHECK: if (chk_done_i) st_d = chk_pass_i ? PS_RECV : PS_SLEEP;
        PS_RECV:  if (off_i) st_d = PS_SLEEP;
        default:  st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PS_IDLE;
      in_check_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      in_check_q <= (st_q == PS_CHECK);
    end
  end

  assign sleep_load_o = (st_d == PS_SLEEP) && (st_q != PS_SLEEP);
  assign sleep_run_o  = (st_q == PS_SLEEP);
  assign wake_load_o  = (st_d == PS_WAKE) && (st_q != PS_WAKE);
  assign wake_run_o   = (st_q == PS_WAKE);
  assign fe_pwr_o     = (st_q == PS_WAKE) || (st_q == PS_CHECK) || (st_q == PS_RECV);
  assign chk_start_o  = (st_q == PS_CHECK) && !in_check_q;
  assign rx_mode_o    = (st_q == PS_RECV);

endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq #(
  parameter int SLEEP_W     = 5,
  parameter int EXT_W       = 2,
  parameter int UNIT_CYC    = 1024,
  parameter int STARTUP_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poll_en_i,
  input  logic [SLEEP_W-1:0] sleep_code_i,
  input  logic [EXT_W-1:0]   ext_sel_i,
  input  logic               ext_active_i,
  input  logic               chk_done_i,
  input  logic               chk_pass_i,
  input  logic               off_cmd_i,
  output logic               fe_pwr_o,
  output logic               chk_start_o,
  output logic               rx_mode_o
);
  logic sleep_load, sleep_run, sleep_done;
  logic wake_load, wake_run, wake_done;

  rx_poll_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (poll_en_i),
    .sleep_done_i (sleep_done),
    .wake_done_i  (wake_done),
    .chk_done_i   (chk_done_i),
    .chk_pass_i   (chk_pass_i),
    .off_i        (off_cmd_i),
    .sleep_load_o (sleep_load),
    .sleep_run_o  (sleep_run),
    .wake_load_o  (wake_load),
    .wake_run_o   (wake_run),
    .fe_pwr_o     (fe_pwr_o),
    .chk_start_o  (chk_start_o),
    .rx_mode_o    (rx_mode_o)
  );

  rx_poll_sleep_tmr #(
    .SLEEP_W  (SLEEP_W),
    .EXT_W    (EXT_W),
    .UNIT_CYC (UNIT_CYC)
  ) u_sleep (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (sleep_load),
    .run_i  (sleep_run),
    .code_i (sleep_code_i),
    .sel_i  (ext_sel_i),
    .ext_i  (ext_active_i),
    .done_o (sleep_done)
  );

  rx_poll_wake_tmr #(
    .STARTUP_CYC (STARTUP_CYC)
  ) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wake_load),
    .run_i  (wake_run),
    .done_o (wake_done)
  );

endmodule

// File: rtl/rx_poll_seq_chk.sv
module rx_poll_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic poll_en_i,
  input logic chk_done_i,
  input logic chk_pass_i,
  input logic off_cmd_i,
  input logic fe_pwr_o,
  input logic chk_start_o,
  input logic rx_mode_o
);
  // R2: disabled polling leaves everything dark next cycle
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en_i |=> (!fe_pwr_o && !rx_mode_o && !chk_start_o));

  // R6: strobe is one cycle wide and comes after powered start-up
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start_o |=> !chk_start_o);

  p_strobe_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start_o |-> (fe_pwr_o && $past(fe_pwr_o)));

  // R6: receiving implies powered front end
  p_rx_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode_o |-> fe_pwr_o);

  // R8: receiving only follows a reported pass
  p_rx_needs_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_mode_o) |-> $past(chk_done_i && chk_pass_i));

  // R9: off command ends receiving
  p_off_leaves_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_o && off_cmd_i) |=> (!rx_mode_o && !fe_pwr_o));

endmodule

bind rx_poll_seq rx_poll_seq_chk u_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .poll_en_i   (poll_en_i),
  .chk_done_i  (chk_done_i),
  .chk_pass_i  (chk_pass_i),
  .off_cmd_i   (off_cmd_i),
  .fe_pwr_o    (fe_pwr_o),
  .chk_start_o (chk_start_o),
  .rx_mode_o   (rx_mode_o)
);

// File: tb/rx_poll_seq_test.sv
module rx_poll_seq_test;
  localparam int UNIT  = 1024;
  localparam int START = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       poll_en_i = 1'b0;
  logic [4:0] sleep_code_i = 5'd1;
  logic [1:0] ext_sel_i = 2'd0;
  logic       ext_active_i = 1'b0;
  logic       chk_done_i = 1'b0;
  logic       chk_pass_i = 1'b0;
  logic       off_cmd_i = 1'b0;
  logic       fe_pwr_o, chk_start_o, rx_mode_o;

  int n_chk = 0;
  int n_bad = 0;

  rx_poll_seq uut (
    .clk(clk), .rst_n(rst_n), .poll_en_i(poll_en_i), .sleep_code_i(sleep_code_i),
    .ext_sel_i(ext_sel_i), .ext_active_i(ext_active_i), .chk_done_i(chk_done_i),
    .chk_pass_i(chk_pass_i), .off_cmd_i(off_cmd_i), .fe_pwr_o(fe_pwr_o),
    .chk_start_o(chk_start_o), .rx_mode_o(rx_mode_o)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // count low-power cycles until the front end powers up
  task automatic count_sleep(output int n, input int limit);
    n = 0;
    while (!fe_pwr_o && n < limit) begin n++; step(); end
  endtask

  // from first powered cycle to the check strobe; optional early pass pulse
  task automatic run_wake(output int n, output bit rx_seen, input bit glitch);
    n = 0; rx_seen = 0;
    while (!chk_start_o && n < 10000) begin
      n++;
      if (rx_mode_o) rx_seen = 1;
      if (glitch && n == 10) begin chk_done_i = 1; chk_pass_i = 1; end
      if (glitch && n == 15) begin chk_done_i = 0; chk_pass_i = 0; end
      step();
    end
  endtask

  task automatic fail_check();
    chk_done_i = 1; chk_pass_i = 0;
    step();
    chk_done_i = 0;
  endtask

  task automatic t_reset();
    step();
    check(!fe_pwr_o && !chk_start_o && !rx_mode_o, "R1 outputs in reset", fe_pwr_o, 0);
    rst_n = 1;
    repeat (2000) begin
      step();
      if (fe_pwr_o || rx_mode_o) break;
    end
    check(!fe_pwr_o && !rx_mode_o, "R2 idle while disabled", fe_pwr_o, 0);
  endtask

  task automatic t_first_loop();
    int n; bit rx;
    sleep_code_i = 5'd1;
    poll_en_i = 1;
    step();
    count_sleep(n, 70000);
    check(n == UNIT, "R3 first sleep length code 1", n, UNIT);
    run_wake(n, rx, 0);
    check(n == START, "R6 start-up length", n, START);
    check(fe_pwr_o && chk_start_o, "R6 strobe with power", chk_start_o, 1);
    step();
    check(!chk_start_o && fe_pwr_o, "R6 strobe single cycle", chk_start_o, 0);
  endtask

  task automatic t_sleep_len(input logic [4:0] code, input bit ext, input logic [1:0] sel,
                             input int exp, input string req);
    int n; bit rx;
    sleep_code_i = code; ext_active_i = ext; ext_sel_i = sel;
    fail_check();
    check(!fe_pwr_o, "R8 fail powers down", fe_pwr_o, 0);
    // change config mid-sleep: must not affect this period (R4)
    ext_active_i = 0; sleep_code_i = 5'd2;
    count_sleep(n, 70000);
    check(n == exp, req, n, exp);
    run_wake(n, rx, 0);
  endtask

  task automatic t_early_result();
    int n; bit rx;
    sleep_code_i = 5'd1; ext_active_i = 0;
    fail_check();
    count_sleep(n, 70000);
    run_wake(n, rx, 1);
    check(n == START, "R7 start-up not shortened", n, START);
    check(!rx && !rx_mode_o, "R7 no receive from early pass", rx_mode_o, 0);
  endtask

  task automatic t_pass_off();
    int n;
    chk_done_i = 1; chk_pass_i = 1;
    step();
    chk_done_i = 0; chk_pass_i = 0;
    check(rx_mode_o && fe_pwr_o, "R8 pass enters receiving", rx_mode_o, 1);
    repeat (100) step();
    check(rx_mode_o, "R8 receiving held", rx_mode_o, 1);
    sleep_code_i = 5'd3;
    off_cmd_i = 1;
    step();
    off_cmd_i = 0;
    check(!rx_mode_o && !fe_pwr_o, "R9 off leaves receiving", rx_mode_o, 0);
    count_sleep(n, 70000);
    check(n == 3 * UNIT, "R9 new sleep after off", n, 3 * UNIT);
  endtask

  task automatic t_disable_in_rx();
    int n; bit rx;
    run_wake(n, rx, 0);
    chk_done_i = 1; chk_pass_i = 1;
    step();
    chk_done_i = 0; chk_pass_i = 0;
    poll_en_i = 0;
    step();
    check(!rx_mode_o && !fe_pwr_o && !chk_start_o, "R2 disable exits receiving", rx_mode_o, 0);
    n = 0;
    repeat (3000) begin step(); if (fe_pwr_o) n++; end
    check(n == 0, "R2 stays idle", n, 0);
  endtask

  task automatic t_permanent();
    int n; bit rx;
    sleep_code_i = 5'd1;
    poll_en_i = 1;
    step();
    count_sleep(n, 70000);
    run_wake(n, rx, 0);
    sleep_code_i = 5'd31;
    fail_check();
    count_sleep(n, 40000);
    check(n == 40000, "R5 permanent sleep holds", n, 40000);
    sleep_code_i = 5'd1;
    count_sleep(n, 5000);
    check(n == 5000, "R5 code change ignored", n, 5000);
    poll_en_i = 0;
    step(); step();
    poll_en_i = 1;
    step();
    count_sleep(n, 70000);
    check(n == UNIT, "R5 restart via enable", n, UNIT);
  endtask

  initial begin
    t_reset();
    t_first_loop();
    t_sleep_len(5'd3, 1'b0, 2'd3, 3 * UNIT, "R3 sleep code 3");
    t_sleep_len(5'd0, 1'b0, 2'd0, 1, "R3 zero code one cycle");
    t_sleep_len(5'd2, 1'b1, 2'd2, 8 * UNIT, "R4 code 2 factor 4");
    t_sleep_len(5'd3, 1'b1, 2'd1, 6 * UNIT, "R4 code 3 factor 2");
    t_sleep_len(5'd1, 1'b1, 2'd3, 8 * UNIT, "R4 code 1 factor 8");
    t_sleep_len(5'd2, 1'b0, 2'd3, 2 * UNIT, "R4 factor ignored when inactive");
    t_early_result();
    t_pass_off();
    t_disable_in_rx();
    t_permanent();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule